// File: doc/BRIEF.md
# ROM Bank Selector

This block decides, for every CPU memory access, whether the access is served by the boot EPROM or by RAM, and which EPROM byte it reaches. The CPU address space is cut into four 16 KB windows by its top two address bits. The bottom window and the top window can each be overlaid by ROM, and each overlay has its own enable flag. These flags come from the mode register, which lives outside this block. A single 64 KB EPROM holds four 16 KB images. The bottom window always reaches the image at EPROM quarter 0. The top window reaches one of the three remaining images. Which one depends on a bank number that software writes into a write-only register through an I/O cycle.

A small state machine holds the selected image. It has three states. `IMG_DEFAULT` selects EPROM quarter 1 (offset 4000h). `IMG_MENU` selects quarter 3 (offset C000h). `IMG_DOS` selects quarter 2 (offset 8000h). A bank write with data 03h takes the transition *load-menu* into `IMG_MENU`. Data 07h takes *load-dos* into `IMG_DOS`. Any other byte takes *load-default* into `IMG_DEFAULT`. An I/O write that is not addressed to the bank register takes *hold*.

A second state machine registers each access result. Its states are `ACC_IDLE`, `ACC_ROM` and `ACC_RAM`. Each cycle it takes *to-idle* when there is no request, *to-rom* for an enabled ROM read, and *to-ram* for everything else. The EPROM address is the 2-bit image base joined to the low 14 CPU address bits.

Top module: `rom_bank_sel`

## Requirements
- R1: While reset is asserted, and at the first clock edge after it, `acc_valid`, `rom_cs` and `ram_sel` are 0 and `rom_addr` is 0000h. Reset puts the image selector into the state of bank 00h.
- R2: A bank write is an `io_wr` cycle with `io_addr[13]` = 0, and it loads `io_data` as the bank number. An `io_wr` cycle with `io_addr[13]` = 1 leaves the selected image unchanged.
- R3: With bank 00h selected, an enabled top-window read gives `rom_addr[15:14]` = 2'b01.
- R4: With bank 03h selected, an enabled top-window read gives `rom_addr[15:14]` = 2'b11.
- R5: With bank 07h selected, an enabled top-window read gives `rom_addr[15:14]` = 2'b10.
- R6: Every bank number other than 03h and 07h gives the same image as bank 00h (`rom_addr[15:14]` = 2'b01).
- R7: A read with `cpu_addr[15:14]` = 2'b00 and `lo_rom_en` = 1 gives `rom_cs` = 1, `ram_sel` = 0 and `rom_addr` = {2'b00, `cpu_addr[13:0]`}.
- R8: A read with `cpu_addr[15:14]` = 2'b11 and `hi_rom_en` = 1 gives `rom_cs` = 1, `ram_sel` = 0 and `rom_addr` = {image base, `cpu_addr[13:0]`}.
- R9: The following reads give `ram_sel` = 1, `rom_cs` = 0 and `rom_addr` = 0: a read in a disabled ROM window, and a read with `cpu_addr[15:14]` equal to 01 or 10.
- R10: A memory write (`mem_wr` = 1, whether or not `mem_rd` is also 1) gives `ram_sel` = 1, `rom_cs` = 0 and `rom_addr` = 0, whatever the window and enables.
- R11: Results appear exactly one cycle after the request: `acc_valid` is 1 for one cycle per requesting cycle. A cycle without request gives all outputs 0 on the next cycle.
- R12: A read presented in the same cycle as a bank write uses the previous image. A read presented on the following cycle uses the new image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O address; bit 13 low selects the bank register |
| io_data | input | 8 | I/O write data (bank number) |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| cpu_addr | input | 16 | CPU memory address |
| lo_rom_en | input | 1 | Bottom-window ROM overlay enable |
| hi_rom_en | input | 1 | Top-window ROM overlay enable |
| acc_valid | output | 1 | Result valid, one cycle after request |
| rom_cs | output | 1 | EPROM chip select |
| ram_sel | output | 1 | RAM select |
| rom_addr | output | 16 | EPROM byte address |

## Verification
Each access result is due one cycle after its request. When the driver presents a request, it pushes an expectation tagged with the cycle number in which that result is due. The monitor looks at the outputs 1 ns after each falling edge and compares only the expectations whose due cycle equals the current cycle. Idle cycles get an all-zero expectation, so a late or extra result is also caught.

A bank write changes the image used by requests presented from the next cycle onward. The bench model therefore builds the expectation for a request from the bank value held before that cycle's write. After that it applies the write.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

    // Selected top-window image
    typedef enum logic [1:0] {
        IMG_DEFAULT = 2'd0,
        IMG_MENU    = 2'd1,
        IMG_DOS     = 2'd2
    } img_state_t;

    // Kind of CPU window an address falls in
    typedef enum logic [1:0] {
        WIN_LOW  = 2'd0,
        WIN_MID  = 2'd1,
        WIN_HIGH = 2'd2
    } win_kind_t;

    // Registered access result
    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_ROM  = 2'd1,
        ACC_RAM  = 2'd2
    } acc_kind_t;

endpackage

// File: rtl/rbs_bank_fsm.sv
module rbs_bank_fsm
    import rbs_pkg::*;
#(
    parameter int                IO_ADDR_W = 16,
    parameter int                DATA_W    = 8,
    parameter int                SEL_BIT   = 13,
    parameter int                BASE_W    = 2,
    parameter logic [DATA_W-1:0] MENU_BANK = 8'h03,
    parameter logic [DATA_W-1:0] DOS_BANK  = 8'h07,
    parameter logic [BASE_W-1:0] DFLT_BASE = 2'b01,
    parameter logic [BASE_W-1:0] MENU_BASE = 2'b11,
    parameter logic [BASE_W-1:0] DOS_BASE  = 2'b10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 io_wr,
    input  logic [IO_ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0]    io_data,
    output logic [BASE_W-1:0]    img_base
);

    img_state_t state_q;
    img_state_t state_n;
    logic       bank_wr;
    logic       io_addr_unused;

    assign io_addr_unused = ^io_addr;
    assign bank_wr        = io_wr && !io_addr[SEL_BIT];

    // Next-state decision
    always_comb begin
        state_n = state_q;
        if (bank_wr) begin
            if (io_data == MENU_BANK) begin
                state_n = IMG_MENU;
            end else if (io_data == DOS_BANK) begin
                state_n = IMG_DOS;
            end else begin
                state_n = IMG_DEFAULT;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IMG_DEFAULT;
        end else begin
            state_q <= state_n;
        end
    end

    // State to image base
    always_comb begin
        unique case (state_q)
            IMG_DEFAULT: img_base = DFLT_BASE;
            IMG_MENU:    img_base = MENU_BASE;
            IMG_DOS:     img_base = DOS_BASE;
            default:     img_base = DFLT_BASE;
        endcase
    end

    // R2
    foreign_io_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr[SEL_BIT]) |=> $stable(img_base));

    // R4
    menu_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && io_data == MENU_BANK) |=> (img_base == MENU_BASE));

    // R5
    dos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && io_data == DOS_BANK) |=> (img_base == DOS_BASE));

    // R6
    other_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_wr && io_data != MENU_BANK && io_data != DOS_BANK)
        |=> (img_base == DFLT_BASE));

endmodule

// File: rtl/rbs_window_dec.sv
module rbs_window_dec
    import rbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN_W  = 2
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    output win_kind_t         win
);

    logic [WIN_W-1:0] top_bits;

    assign top_bits = cpu_addr[ADDR_W-1 -: WIN_W];

    always_comb begin
        if (top_bits == '0) begin
            win = WIN_LOW;
        end else if (top_bits == '1) begin
            win = WIN_HIGH;
        end else begin
            win = WIN_MID;
        end
    end

endmodule

// File: rtl/rbs_out_stage.sv
module rbs_out_stage
    import rbs_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter int                WIN_W    = 2,
    parameter int                BASE_W   = 2,
    parameter logic [BASE_W-1:0] LOW_BASE = 2'b00,
    localparam int               OFS_W    = ADDR_W - WIN_W,
    localparam int               ROM_AW   = BASE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  win_kind_t         win,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic [BASE_W-1:0] img_base,
    output logic              acc_valid,
    output logic              rom_cs,
    output logic              ram_sel,
    output logic [ROM_AW-1:0] rom_addr
);

    acc_kind_t         kind_q;
    acc_kind_t         kind_n;
    logic [ROM_AW-1:0] addr_q;
    logic [ROM_AW-1:0] addr_n;
    logic [OFS_W-1:0]  ofs;

    assign ofs = cpu_addr[OFS_W-1:0];

    // Next-state decision
    always_comb begin
        kind_n = ACC_IDLE;
        addr_n = '0;
        if (mem_wr) begin
            kind_n = ACC_RAM;
        end else if (mem_rd) begin
            unique case (win)
                WIN_LOW: begin
                    if (lo_en) begin
                        kind_n = ACC_ROM;
                        addr_n = {LOW_BASE, ofs};
                    end else begin
                        kind_n = ACC_RAM;
                    end
                end
                WIN_HIGH: begin
                    if (hi_en) begin
                        kind_n = ACC_ROM;
                        addr_n = {img_base, ofs};
                    end else begin
                        kind_n = ACC_RAM;
                    end
                end
                default: kind_n = ACC_RAM;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= ACC_IDLE;
            addr_q <= '0;
        end else begin
            kind_q <= kind_n;
            addr_q <= addr_n;
        end
    end

    // Outputs from state
    always_comb begin
        acc_valid = 1'b0;
        rom_cs    = 1'b0;
        ram_sel   = 1'b0;
        rom_addr  = '0;
        unique case (kind_q)
            ACC_IDLE: ;
            ACC_ROM: begin
                acc_valid = 1'b1;
                rom_cs    = 1'b1;
                rom_addr  = addr_q;
            end
            ACC_RAM: begin
                acc_valid = 1'b1;
                ram_sel   = 1'b1;
            end
            default: ;
        endcase
    end

    // R11
    valid_tracks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |=> acc_valid);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd || mem_wr) |=> (!acc_valid && !rom_cs && !ram_sel));

    // R10
    write_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (ram_sel && !rom_cs));

    // R9
    mid_to_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr && win == WIN_MID) |=> (ram_sel && !rom_cs));

    // R7
    low_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr && win == WIN_LOW && lo_en)
        |=> (rom_cs && rom_addr[ROM_AW-1 -: BASE_W] == LOW_BASE));

    // R8
    high_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_wr && win == WIN_HIGH && hi_en)
        |=> (rom_cs && rom_addr[ROM_AW-1 -: BASE_W] == $past(img_base)));

    // R7
    rom_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> (rom_addr[OFS_W-1:0] == $past(cpu_addr[OFS_W-1:0])));

endmodule

// File: rtl/rom_bank_sel.sv
module rom_bank_sel
    import rbs_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WIN_W     = 2,
    parameter int SEL_BIT   = 13,
    localparam int OFS_W    = ADDR_W - WIN_W,
    localparam int ROM_AW   = WIN_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [DATA_W-1:0] io_data,
    input  logic              mem_rd,
    input  logic              mem_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lo_rom_en,
    input  logic              hi_rom_en,
    output logic              acc_valid,
    output logic              rom_cs,
    output logic              ram_sel,
    output logic [ROM_AW-1:0] rom_addr
);

    logic [WIN_W-1:0] img_base;
    win_kind_t        win;

    rbs_bank_fsm #(
        .IO_ADDR_W (ADDR_W),
        .DATA_W    (DATA_W),
        .SEL_BIT   (SEL_BIT),
        .BASE_W    (WIN_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_wr    (io_wr),
        .io_addr  (io_addr),
        .io_data  (io_data),
        .img_base (img_base)
    );

    rbs_window_dec #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W)
    ) u_win (
        .cpu_addr (cpu_addr),
        .win      (win)
    );

    rbs_out_stage #(
        .ADDR_W (ADDR_W),
        .WIN_W  (WIN_W),
        .BASE_W (WIN_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .cpu_addr  (cpu_addr),
        .win       (win),
        .lo_en     (lo_rom_en),
        .hi_en     (hi_rom_en),
        .img_base  (img_base),
        .acc_valid (acc_valid),
        .rom_cs    (rom_cs),
        .ram_sel   (ram_sel),
        .rom_addr  (rom_addr)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!acc_valid && !rom_cs && !ram_sel && rom_addr == '0));

endmodule

// File: tb/rom_bank_sel_bench.sv
`timescale 1ns/1ps
module rom_bank_sel_bench;

    typedef struct {
        int          due;
        logic        v;
        logic        cs;
        logic        ram;
        logic [15:0] ad;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [7:0]  io_data = 8'h0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic [15:0] cpu_addr = 16'h0;
    logic        lo_rom_en = 1'b0;
    logic        hi_rom_en = 1'b0;
    logic        acc_valid;
    logic        rom_cs;
    logic        ram_sel;
    logic [15:0] rom_addr;

    int   checks = 0;
    int   failures = 0;
    int   cyc = 0;
    bit   done = 1'b0;
    logic [7:0] bank_model = 8'h00;
    exp_t q[$];

    rom_bank_sel u_rom_bank_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_wr     (io_wr),
        .io_addr   (io_addr),
        .io_data   (io_data),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .cpu_addr  (cpu_addr),
        .lo_rom_en (lo_rom_en),
        .hi_rom_en (hi_rom_en),
        .acc_valid (acc_valid),
        .rom_cs    (rom_cs),
        .ram_sel   (ram_sel),
        .rom_addr  (rom_addr)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [1:0] base_of(input logic [7:0] b);
        if (b == 8'h03) return 2'b11;       // R4
        else if (b == 8'h07) return 2'b10;  // R5
        else return 2'b01;                  // R3, R6
    endfunction

    task automatic check(input string tag, input logic [18:0] act, input logic [18:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: got v/cs/ram/addr=%b/%b/%b/%h expected %b/%b/%b/%h",
                     tag, act[18], act[17], act[16], act[15:0],
                     exp[18], exp[17], exp[16], exp[15:0]);
        end
    endtask

    // Driver: presents one cycle of stimulus and pushes its expected result
    task automatic step(input logic iw, input logic [15:0] ia, input logic [7:0] id,
                        input logic rd, input logic wr, input logic [15:0] a,
                        input string tag);
        exp_t e;
        io_wr = iw; io_addr = ia; io_data = id;
        mem_rd = rd; mem_wr = wr; cpu_addr = a;
        e.due = cyc + 1; e.tag = tag;
        e.v = 1'b0; e.cs = 1'b0; e.ram = 1'b0; e.ad = 16'h0;
        if (wr) begin
            e.v = 1'b1; e.ram = 1'b1;                       // R10
        end else if (rd) begin
            e.v = 1'b1;
            if (a[15:14] == 2'b00 && lo_rom_en) begin       // R7
                e.cs = 1'b1; e.ad = {2'b00, a[13:0]};
            end else if (a[15:14] == 2'b11 && hi_rom_en) begin  // R8
                e.cs = 1'b1; e.ad = {base_of(bank_model), a[13:0]};
            end else begin
                e.ram = 1'b1;                               // R9
            end
        end
        q.push_back(e);
        if (iw && !ia[13]) bank_model = id;                 // R2, R12
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 16'h0, 8'h0, 1'b0, 1'b0, 16'h0, tag);
    endtask

    task automatic bank_write(input logic [7:0] b, input string tag);
        step(1'b1, 16'hDF00, b, 1'b0, 1'b0, 16'h0, tag);
    endtask

    task automatic high_read(input logic [15:0] a, input string tag);
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, a, tag);
    endtask

    // Monitor: compares results in the cycle they are due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].due == cyc) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {acc_valid, rom_cs, ram_sel, rom_addr},
                      {e.v, e.cs, e.ram, e.ad});
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        mem_rd = 1'b1; cpu_addr = 16'hC123; hi_rom_en = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset holds outputs quiet even with a request pending
        check("R1 in reset", {acc_valid, rom_cs, ram_sel, rom_addr}, 19'h0);
        mem_rd = 1'b0;
        rst_n = 1'b1;
        idle("R1 first idle");
        lo_rom_en = 1'b1; hi_rom_en = 1'b1;

        // R1, R3: reset image is bank 00h
        high_read(16'hC123, "R1 R3 reset image");
        // R7: low window ROM
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'h2ABC, "R7 low rom");
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'h0000, "R7 low rom bottom");
        // R9: middle windows go to RAM
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'h4001, "R9 mid window 01");
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'hBFFF, "R9 mid window 10");
        // R10: writes in ROM windows go to RAM
        step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 16'h1234, "R10 low write");
        step(1'b0, 16'h0, 8'h0, 1'b0, 1'b1, 16'hFFFF, "R10 high write");
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b1, 16'hC000, "R10 read+write");
        idle("R11 idle");

        // R4
        bank_write(8'h03, "R4 write");
        high_read(16'hFFFF, "R4 menu image");
        // R5
        bank_write(8'h07, "R5 write");
        high_read(16'hC555, "R5 dos image");
        // R2: write with address bit 13 set is ignored
        step(1'b1, 16'hFFFF, 8'h03, 1'b0, 1'b0, 16'h0, "R2 foreign write");
        high_read(16'hC00F, "R2 image kept");
        // R6: others fold to default
        bank_write(8'h01, "R6 write 01");
        high_read(16'hC010, "R6 bank 01");
        bank_write(8'h07, "R6 reload");
        bank_write(8'h02, "R6 write 02");
        high_read(16'hC020, "R6 bank 02");
        bank_write(8'h03, "R6 reload");
        bank_write(8'h04, "R6 write 04");
        high_read(16'hC040, "R6 bank 04");
        bank_write(8'h07, "R6 reload");
        bank_write(8'h06, "R6 write 06");
        high_read(16'hC060, "R6 bank 06");
        bank_write(8'h03, "R6 reload");
        bank_write(8'h08, "R6 write 08");
        high_read(16'hC080, "R6 bank 08");
        bank_write(8'h07, "R6 reload");
        bank_write(8'hFF, "R6 write FF");
        high_read(16'hDFFF, "R6 bank FF");
        // R3: back to bank 00h
        bank_write(8'h03, "R3 reload");
        bank_write(8'h00, "R3 write 00");
        high_read(16'hE000, "R3 bank 00");

        // R12: read in the same cycle as the write sees the old image
        step(1'b1, 16'hDF00, 8'h03, 1'b1, 1'b0, 16'hC777, "R12 same cycle");
        high_read(16'hC777, "R12 next cycle");

        // R9: disabled windows go to RAM
        hi_rom_en = 1'b0;
        high_read(16'hC100, "R9 high disabled");
        lo_rom_en = 1'b0;
        step(1'b0, 16'h0, 8'h0, 1'b1, 1'b0, 16'h0100, "R9 low disabled");
        hi_rom_en = 1'b1;
        high_read(16'hC100, "R8 re-enabled");
        // R11: back-to-back idle after a read
        idle("R11 idle after read");
        idle("R11 idle 2");
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            failures++;
            $display("FAIL R11 queue drain: got %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule